// File: doc/BRIEF.md
# Three-Operand ALU With Void Destination

This block is the execute stage of a 16-bit machine whose every instruction has the shape `R = Y op X`. It receives a 4-bit opcode, two data operands, a 4-bit in-place immediate, a condition selector and the destination code. One clock edge after an operation is presented, it supplies the result, a result write-enable and the updated flags. It keeps the flag register itself, because carry-in, borrow-in and the conditional add all read it.

It supports three kinds of arithmetic: plain, carry-chained and flag-preserving ("silent") adds. It also supports subtracts, the three bitwise operations, a conditional add and a cyclic right rotate. The adds and the rotate also have a form that takes the immediate instead of X. There is no separate test opcode for comparisons or bit tests. Software writes to one reserved destination code, the void destination. For that code the flags update as usual, but the result write is suppressed. A compare opcode that hands Y back unchanged is also kept.

Top module: `tri_op_alu`

## Requirements
- R1: While reset is high and in the cycle after it, `res_we` is 0, `res_q` is 0 and `flags_q` is 0. `flags_q` packs Zero in bit 3, Carry in bit 2, Negative in bit 1 and Overflow in bit 0.
- R2: The opcode values are 0 ADDIS, 1 ADDI, 2 ADDS, 3 ADD, 4 ADC, 5 SUB, 6 SBC, 7 AND, 8 OR, 9 XOR, 10 CMP, 11 CADD, 12 RRCI and 13 RRC. ADD returns Y+X and ADDI returns Y plus the sign-extended immediate (-8..+7). Both set Zero, Negative, Carry (carry-out) and Overflow (signed) from that sum.
- R3: ADDS, ADDIS and CADD leave all four flags unchanged. ADDS returns Y+X and ADDIS returns Y plus the sign-extended immediate.
- R4: ADC adds the current Carry as carry-in. SBC subtracts the current Carry as borrow-in.
- R5: SUB returns Y-X. Carry is set when a borrow occurs (Y < X unsigned), and Overflow is set on signed overflow.
- R6: CMP sets the flags exactly as SUB would, and returns Y unchanged as its result.
- R7: AND, OR and XOR return the bitwise result. They set Zero and Negative from it, and clear Carry and Overflow.
- R8: RRC rotates Y right cyclically by X[3:0] bits, and RRCI does the same by the low four bits of the immediate. For a count n, Carry takes Y[n], Zero and Negative follow the result, and Overflow is cleared.
- R9: CADD returns Y+X when the selected condition holds against the current flags, and Y otherwise. The condition codes are 0 always, 1 Zero, 2 not Zero, 3 Carry, 4 not Carry, 5 Negative, 6 not Negative and 7 Overflow.
- R10: When `dst_code` equals the void code (15 by default), `res_we` stays 0 but the flags update as for any other destination.
- R11: Opcodes 14 and 15 raise no write and leave the flags unchanged.
- R12: Results, write-enable and flags appear one cycle after `op_valid` is sampled high. A cycle without `op_valid` gives `res_we` 0 and holds the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation selector |
| dst_code | input | 4 | Destination code; the void code suppresses the write |
| cond_sel | input | 3 | Condition for the conditional add |
| imm_in | input | 4 | Signed in-place immediate |
| opnd_y | input | 16 | First operand |
| opnd_x | input | 16 | Second operand |
| res_q | output | 16 | Registered result |
| res_we | output | 1 | Result write-enable |
| flags_q | output | 4 | Flags {Zero, Carry, Negative, Overflow} |

## Verification
The assertions assume that `op_valid`, `op_code` and `dst_code` hold known values from the first clock after reset, and that `op_valid` is low during reset. The stimulus drives every input to a defined value on the falling edge, holds `op_valid` low while reset is active, and presents each operation for exactly one cycle. The directed operands are chained so that the carry, borrow and condition cases each meet a known flag state left by the step before them.

// File: rtl/tri_op_alu_pkg.sv
package tri_op_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADDIS = 4'd0,
        OP_ADDI  = 4'd1,
        OP_ADDS  = 4'd2,
        OP_ADD   = 4'd3,
        OP_ADC   = 4'd4,
        OP_SUB   = 4'd5,
        OP_SBC   = 4'd6,
        OP_AND   = 4'd7,
        OP_OR    = 4'd8,
        OP_XOR   = 4'd9,
        OP_CMP   = 4'd10,
        OP_CADD  = 4'd11,
        OP_RRCI  = 4'd12,
        OP_RRC   = 4'd13
    } op_e;

    typedef enum logic [2:0] {
        CC_ALWAYS = 3'd0,
        CC_Z      = 3'd1,
        CC_NZ     = 3'd2,
        CC_C      = 3'd3,
        CC_NC     = 3'd4,
        CC_N      = 3'd5,
        CC_NN     = 3'd6,
        CC_V      = 3'd7
    } cc_e;

    typedef struct packed {
        logic z;
        logic c;
        logic n;
        logic v;
    } flags_t;

    function automatic logic cond_true(input logic [2:0] sel, input flags_t f);
        case (cc_e'(sel))
            CC_ALWAYS: return 1'b1;
            CC_Z:      return f.z;
            CC_NZ:     return !f.z;
            CC_C:      return f.c;
            CC_NC:     return !f.c;
            CC_N:      return f.n;
            CC_NN:     return !f.n;
            default:   return f.v;
        endcase
    endfunction

endpackage

// File: rtl/tri_op_addsub.sv
module tri_op_addsub #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    input  logic          sub,
    output logic [DW-1:0] sum,
    output logic          cout,
    output logic          ovf
);
    logic [DW-1:0] b_eff;
    logic          c_eff;
    logic          co_raw;

    // Subtraction as a + ~b + ~borrow; carry-out inverted back into a borrow.
    always_comb begin
        b_eff = sub ? ~b : b;
        c_eff = sub ? ~cin : cin;
        {co_raw, sum} = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, c_eff};
        cout = sub ? ~co_raw : co_raw;
        ovf  = (a[DW-1] == b_eff[DW-1]) && (sum[DW-1] != a[DW-1]);
    end
endmodule

// File: rtl/tri_op_rotr.sv
module tri_op_rotr #(
    parameter int DW   = 16,
    parameter int CNTW = $clog2(DW)
) (
    input  logic [DW-1:0]   din,
    input  logic [CNTW-1:0] cnt,
    output logic [DW-1:0]   dout,
    output logic            cout
);
    logic [2*DW-1:0] wide;

    always_comb begin
        wide = {din, din} >> cnt;
        dout = wide[DW-1:0];
        cout = din[cnt];
    end
endmodule

// File: rtl/tri_op_alu.sv
module tri_op_alu
    import tri_op_alu_pkg::*;
#(
    parameter int              DW       = 16,
    parameter int              IMMW     = 4,
    parameter int              DSTW     = 4,
    parameter logic [DSTW-1:0] VOID_DST = {DSTW{1'b1}}
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            op_valid,
    input  logic [3:0]      op_code,
    input  logic [DSTW-1:0] dst_code,
    input  logic [2:0]      cond_sel,
    input  logic [IMMW-1:0] imm_in,
    input  logic [DW-1:0]   opnd_y,
    input  logic [DW-1:0]   opnd_x,
    output logic [DW-1:0]   res_q,
    output logic            res_we,
    output logic [3:0]      flags_q
);
    localparam int CNTW = $clog2(DW);

    op_e           op;
    flags_t        fl;
    flags_t        nxt_fl;
    logic [DW-1:0] imm_sx;
    logic [DW-1:0] add_b;
    logic          add_sub;
    logic          add_cin;
    logic [DW-1:0] add_sum;
    logic          add_co;
    logic          add_ov;
    logic [CNTW-1:0] rot_n;
    logic [DW-1:0] rot_out;
    logic          rot_co;
    logic [DW-1:0] nxt_res;
    logic          known;

    assign op      = op_e'(op_code);
    assign imm_sx  = {{(DW-IMMW){imm_in[IMMW-1]}}, imm_in};
    assign flags_q = fl;

    // Operand steering for the shared adder and the rotator.
    always_comb begin
        add_b   = opnd_x;
        add_sub = 1'b0;
        add_cin = 1'b0;
        rot_n   = opnd_x[CNTW-1:0];
        case (op)
            OP_ADDIS, OP_ADDI: add_b = imm_sx;
            OP_ADC:            add_cin = fl.c;
            OP_SUB, OP_CMP:    add_sub = 1'b1;
            OP_SBC: begin
                add_sub = 1'b1;
                add_cin = fl.c;
            end
            OP_CADD:           add_b = cond_true(cond_sel, fl) ? opnd_x : '0;
            OP_RRCI:           rot_n = imm_sx[CNTW-1:0];
            default: ;
        endcase
    end

    tri_op_addsub #(.DW(DW)) u_addsub (
        .a    (opnd_y),
        .b    (add_b),
        .cin  (add_cin),
        .sub  (add_sub),
        .sum  (add_sum),
        .cout (add_co),
        .ovf  (add_ov)
    );

    tri_op_rotr #(.DW(DW), .CNTW(CNTW)) u_rotr (
        .din  (opnd_y),
        .cnt  (rot_n),
        .dout (rot_out),
        .cout (rot_co)
    );

    // Result selection and flag update.
    always_comb begin
        nxt_res = opnd_y;
        nxt_fl  = fl;
        known   = 1'b1;
        case (op)
            OP_ADDIS, OP_ADDS, OP_CADD: nxt_res = add_sum;
            OP_ADDI, OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP: begin
                if (op != OP_CMP) nxt_res = add_sum;
                nxt_fl.z = (add_sum == '0);
                nxt_fl.c = add_co;
                nxt_fl.n = add_sum[DW-1];
                nxt_fl.v = add_ov;
            end
            OP_AND, OP_OR, OP_XOR: begin
                if (op == OP_AND)     nxt_res = opnd_y & opnd_x;
                else if (op == OP_OR) nxt_res = opnd_y | opnd_x;
                else                  nxt_res = opnd_y ^ opnd_x;
                nxt_fl.z = (nxt_res == '0);
                nxt_fl.c = 1'b0;
                nxt_fl.n = nxt_res[DW-1];
                nxt_fl.v = 1'b0;
            end
            OP_RRC, OP_RRCI: begin
                nxt_res  = rot_out;
                nxt_fl.z = (rot_out == '0);
                nxt_fl.c = rot_co;
                nxt_fl.n = rot_out[DW-1];
                nxt_fl.v = 1'b0;
            end
            default: known = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            res_we <= 1'b0;
            fl     <= '0;
        end else begin
            res_we <= op_valid && known && (dst_code != VOID_DST);
            if (op_valid) begin
                res_q <= nxt_res;
                fl    <= nxt_fl;
            end
        end
    end
endmodule

// File: rtl/tri_op_alu_chk.sv
module tri_op_alu_chk #(
    parameter int              DW       = 16,
    parameter int              DSTW     = 4,
    parameter logic [DSTW-1:0] VOID_DST = {DSTW{1'b1}}
) (
    input logic            clk,
    input logic            rst,
    input logic            op_valid,
    input logic [3:0]      op_code,
    input logic [DSTW-1:0] dst_code,
    input logic [DW-1:0]   opnd_y,
    input logic [DW-1:0]   res_q,
    input logic            res_we,
    input logic [3:0]      flags_q
);
    a_r12_no_write_when_idle: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> !res_we);

    a_r12_flags_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable(flags_q));

    a_r10_void_suppresses_write: assert property (@(posedge clk) disable iff (rst)
        (op_valid && dst_code == VOID_DST) |=> !res_we);

    a_r3_silent_keeps_flags: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_code == 4'd0 || op_code == 4'd2 || op_code == 4'd11)) |=> $stable(flags_q));

    a_r6_cmp_returns_y: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 4'd10) |=> (res_q == $past(opnd_y)));

    a_r11_undefined_inert: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code > 4'd13) |=> (!res_we && $stable(flags_q)));

    a_r7_logic_clears_cv: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code >= 4'd7 && op_code <= 4'd9) |=> (!flags_q[2] && !flags_q[0]));

    a_r2_add_zero_matches: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 4'd3) |=> (flags_q[3] == (res_q == '0)));
endmodule

bind tri_op_alu tri_op_alu_chk #(.DW(DW), .DSTW(DSTW), .VOID_DST(VOID_DST)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .op_code  (op_code),
    .dst_code (dst_code),
    .opnd_y   (opnd_y),
    .res_q    (res_q),
    .res_we   (res_we),
    .flags_q  (flags_q)
);

// File: tb/tri_op_alu_tb.sv
`timescale 1ns/1ps
module tri_op_alu_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic [3:0]  dst_code = 4'd0;
    logic [2:0]  cond_sel = 3'd0;
    logic [3:0]  imm_in = 4'd0;
    logic [15:0] opnd_y = 16'd0;
    logic [15:0] opnd_x = 16'd0;
    logic [15:0] res_q;
    logic        res_we;
    logic [3:0]  flags_q;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    tri_op_alu u_dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .dst_code(dst_code), .cond_sel(cond_sel), .imm_in(imm_in),
        .opnd_y(opnd_y), .opnd_x(opnd_x), .res_q(res_q), .res_we(res_we),
        .flags_q(flags_q)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    // Presents one operation for one cycle; outputs are valid on return.
    task automatic do_op(input logic [3:0] op, input logic [3:0] dst,
                         input logic [15:0] y, input logic [15:0] x,
                         input logic [3:0] imm, input logic [2:0] cc);
        @(negedge clk);
        op_valid = 1'b1; op_code = op; dst_code = dst;
        opnd_y = y; opnd_x = x; imm_in = imm; cond_sel = cc;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic expect_out(input string req, input logic [15:0] r,
                              input logic we, input logic [3:0] f);
        chk({req, " result"}, {16'd0, res_q}, {16'd0, r});
        chk({req, " write"},  {31'd0, res_we}, {31'd0, we});
        chk({req, " flags"},  {28'd0, flags_q}, {28'd0, f});
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_out("R1", 16'h0000, 1'b0, 4'b0000);
    endtask

    task automatic t_add;
        do_op(4'd3, 4'd1, 16'h7FFF, 16'h0001, 4'd0, 3'd0);
        expect_out("R2 add ovf", 16'h8000, 1'b1, 4'b0011);
        do_op(4'd3, 4'd1, 16'hFFFF, 16'h0001, 4'd0, 3'd0);
        expect_out("R2 add carry", 16'h0000, 1'b1, 4'b1100);
        do_op(4'd1, 4'd2, 16'h0005, 16'h0000, 4'hD, 3'd0);
        expect_out("R2 addi neg", 16'h0002, 1'b1, 4'b0100);
    endtask

    task automatic t_silent;
        do_op(4'd2, 4'd1, 16'h0001, 16'h0001, 4'd0, 3'd0);
        expect_out("R3 adds", 16'h0002, 1'b1, 4'b0100);
        do_op(4'd0, 4'd1, 16'h0000, 16'h1234, 4'hF, 3'd0);
        expect_out("R3 addis", 16'hFFFF, 1'b1, 4'b0100);
    endtask

    task automatic t_carry_chain;
        do_op(4'd4, 4'd3, 16'h0001, 16'h0001, 4'd0, 3'd0);
        expect_out("R4 adc", 16'h0003, 1'b1, 4'b0000);
        do_op(4'd5, 4'd3, 16'h0003, 16'h0005, 4'd0, 3'd0);
        expect_out("R5 sub borrow", 16'hFFFE, 1'b1, 4'b0110);
        do_op(4'd6, 4'd3, 16'h000A, 16'h0003, 4'd0, 3'd0);
        expect_out("R4 sbc", 16'h0006, 1'b1, 4'b0000);
        do_op(4'd5, 4'd3, 16'h8000, 16'h0001, 4'd0, 3'd0);
        expect_out("R5 sub ovf", 16'h7FFF, 1'b1, 4'b0001);
    endtask

    task automatic t_cmp_void;
        do_op(4'd10, 4'd2, 16'h1234, 16'h1234, 4'd0, 3'd0);
        expect_out("R6 cmp", 16'h1234, 1'b1, 4'b1000);
        do_op(4'd5, 4'hF, 16'h0005, 16'h0007, 4'd0, 3'd0);
        chk("R10 void sub write", {31'd0, res_we}, 32'd0);
        chk("R10 void sub flags", {28'd0, flags_q}, {28'd0, 4'b0110});
        do_op(4'd1, 4'hF, 16'h0003, 16'h0000, 4'hD, 3'd0);
        chk("R10 void addi write", {31'd0, res_we}, 32'd0);
        chk("R10 void addi flags", {28'd0, flags_q}, {28'd0, 4'b1100});
    endtask

    task automatic t_logic;
        do_op(4'd7, 4'd4, 16'hF0F0, 16'hFF00, 4'd0, 3'd0);
        expect_out("R7 and", 16'hF000, 1'b1, 4'b0010);
        do_op(4'd8, 4'd4, 16'h0000, 16'h0000, 4'd0, 3'd0);
        expect_out("R7 or", 16'h0000, 1'b1, 4'b1000);
        do_op(4'd9, 4'd4, 16'hAAAA, 16'h5555, 4'd0, 3'd0);
        expect_out("R7 xor", 16'hFFFF, 1'b1, 4'b0010);
    endtask

    task automatic t_rotate;
        do_op(4'd13, 4'd5, 16'h0009, 16'h0003, 4'd0, 3'd0);
        expect_out("R8 rrc", 16'h2001, 1'b1, 4'b0100);
        do_op(4'd12, 4'd5, 16'h8001, 16'h0000, 4'd1, 3'd0);
        expect_out("R8 rrci", 16'hC000, 1'b1, 4'b0010);
        do_op(4'd13, 4'd5, 16'h0001, 16'h0010, 4'd0, 3'd0);
        expect_out("R8 rrc zero count", 16'h0001, 1'b1, 4'b0100);
    endtask

    task automatic t_cadd;
        do_op(4'd11, 4'd6, 16'h000A, 16'h0005, 4'd0, 3'd3);
        expect_out("R9 cadd taken", 16'h000F, 1'b1, 4'b0100);
        do_op(4'd11, 4'd6, 16'h000A, 16'h0005, 4'd0, 3'd1);
        expect_out("R9 cadd not taken", 16'h000A, 1'b1, 4'b0100);
        do_op(4'd11, 4'd6, 16'h0001, 16'h0002, 4'd0, 3'd0);
        expect_out("R9 cadd always", 16'h0003, 1'b1, 4'b0100);
    endtask

    task automatic t_undef_idle;
        do_op(4'd14, 4'd1, 16'hFFFF, 16'h0001, 4'd0, 3'd0);
        chk("R11 op14 write", {31'd0, res_we}, 32'd0);
        chk("R11 op14 flags", {28'd0, flags_q}, {28'd0, 4'b0100});
        do_op(4'd15, 4'd1, 16'h0000, 16'h0000, 4'd0, 3'd0);
        chk("R11 op15 write", {31'd0, res_we}, 32'd0);
        chk("R11 op15 flags", {28'd0, flags_q}, {28'd0, 4'b0100});
        @(negedge clk);
        chk("R12 idle write", {31'd0, res_we}, 32'd0);
        chk("R12 idle flags", {28'd0, flags_q}, {28'd0, 4'b0100});
    endtask

    initial begin
        t_reset();
        t_add();
        t_silent();
        t_carry_chain();
        t_cmp_void();
        t_logic();
        t_rotate();
        t_cadd();
        t_undef_idle();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired got running expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule